// File: doc/BRIEF.md
# Masked GPIO Bank Controller with Debug Override

This block manages four 16-bit general-purpose I/O banks spread over two expansion slots. Each slot owns a transmit-side bank and a receive-side bank. A host talks to the block through a simple register port. Each bank has an output-enable register and an output-value register. A write to either one carries a value and a mask, and only the bits selected by the mask change. The host can also read back the pin levels, which pass through a two-flop synchroniser first.

A debug-enable register lets internal debug buses take over pin values. Each of its bits hands one bank's output values to that bank's internal debug bus in place of the host-written value register. The output-enable register still decides which pins actually drive. The block registers its tri-state controls (data and enable) before they reach the pads.

Register indices (5-bit index, 16-bit data):

- Indices 0 to 3 are output-enable for banks 0 to 3.
- Indices 4 to 7 are output-value for banks 0 to 3.
- Indices 8 to 11 are read-only pin levels for banks 0 to 3.
- Index 14 is debug-enable, with bits 3:0 used.

Bank b is slot b/2. Its side is b%2, where 0 is transmit and 1 is receive. On the pin vectors, bank b occupies bits [16b+15:16b].

Top module: `gpio_bank_ctrl`

## Requirements
- R1: On reset, every output-enable bit, output-value bit and debug-enable bit is 0. `pin_oe`, `pin_out` and `host_rdata` read 0.
- R2: A 1 in bit i of a bank's output-enable register sets the matching bit of `pin_oe`. `pin_oe` is a registered copy of the output-enable registers.
- R3: A write to output-enable index b (0 to 3) changes only the bits where `host_wmask` is 1. Those bits take `host_wdata`, and all other bits keep their old value.
- R4: A write to output-value index 4+b changes only the bits where `host_wmask` is 1. Those bits take `host_wdata`, and all other bits keep their old value.
- R5: A read of index 8+b returns bank b's `pin_in` level after two synchronising flops. This holds whether the pin is an input or an output.
- R6: Debug-enable sits at index 14 and is written with the same mask rule. Bit 0 selects slot 0 transmit (bank 0), bit 1 slot 0 receive (bank 1), bit 2 slot 1 transmit (bank 2) and bit 3 slot 1 receive (bank 3).
- R7: While a bank's debug-enable bit is 1, its `pin_out` slice follows that bank's `dbg_bus` slice one cycle later, in place of the output-value register. `pin_oe` is unaffected by the debug-enable bit.
- R8: Writes to indices 8 to 13 and 15 to 31 change no register.
- R9: Reads of indices 12, 13 and 15 to 31 return 0.
- R10: A register write strobed in the cycle before clock edge k appears on `pin_out`/`pin_oe` at edge k+1.
- R11: `host_rdata` updates on the edge where `host_rd` is sampled high. Reads of indices 0 to 7 return the register contents. A read of index 14 returns the debug-enable bits in bits 3:0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 5 | Register index |
| host_wdata | input | 16 | Write value |
| host_wmask | input | 16 | Write bit mask (1 = update bit) |
| host_rdata | output | 16 | Registered read data |
| dbg_bus | input | 64 | Internal debug words, 16 bits per bank |
| pin_in | input | 64 | Pad input levels |
| pin_out | output | 64 | Pad output data |
| pin_oe | output | 64 | Pad output enables (1 = drive) |

## Verification
The properties assume that `host_wr`, `host_rd`, `host_addr`, the write payload, `dbg_bus` and `pin_in` are held stable around the rising edge. They assume nothing about how these inputs relate to one another: a read and a write in the same cycle, an unused index, or a debug bus that changes every cycle are all legal.

The stimulus changes every input only on the falling clock edge. A directed phase covers each index class and each debug-enable bit. A random phase then draws indices from the full 0 to 15 range, with both strobes free and arbitrary masks.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Two banks per slot: transmit side first, receive side second.
  localparam int SIDES = 2;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_OE,
    KIND_VAL,
    KIND_PIN,
    KIND_DBG
  } reg_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int ADDR_W  = 5,
  parameter int DBG_IDX = 14,
  parameter int BIDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BIDX_W-1:0] bank
);

  localparam logic [ADDR_W-1:0] VAL_BASE = ADDR_W'(NBANK);
  localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(2 * NBANK);
  localparam logic [ADDR_W-1:0] END_IDX  = ADDR_W'(3 * NBANK);
  localparam logic [ADDR_W-1:0] DBG_A    = ADDR_W'(DBG_IDX);

  always_comb begin
    kind = KIND_NONE;
    bank = '0;
    if (addr < VAL_BASE) begin
      kind = KIND_OE;
      bank = BIDX_W'(addr);
    end else if (addr < PIN_BASE) begin
      kind = KIND_VAL;
      bank = BIDX_W'(addr - VAL_BASE);
    end else if (addr < END_IDX) begin
      kind = KIND_PIN;
      bank = BIDX_W'(addr - PIN_BASE);
    end else if (addr == DBG_A) begin
      kind = KIND_DBG;
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_oe,
  input  logic         we_val,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] val_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      val_q <= '0;
    end else begin
      if (we_oe)  oe_q  <= (oe_q  & ~wmask) | (wdata & wmask);
      if (we_val) val_q <= (val_q & ~wmask) | (wdata & wmask);
    end
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dbg_sel,
  input  logic [W-1:0] oe_in,
  input  logic [W-1:0] val_in,
  input  logic [W-1:0] dbg_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_oe  <= oe_in;
      pad_out <= dbg_sel ? dbg_in : val_in;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int SLOTS   = 2,
  parameter int BANK_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int DBG_IDX = 14
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            host_wr,
  input  logic                            host_rd,
  input  logic [ADDR_W-1:0]               host_addr,
  input  logic [BANK_W-1:0]               host_wdata,
  input  logic [BANK_W-1:0]               host_wmask,
  output logic [BANK_W-1:0]               host_rdata,
  input  logic [SLOTS*SIDES*BANK_W-1:0]   dbg_bus,
  input  logic [SLOTS*SIDES*BANK_W-1:0]   pin_in,
  output logic [SLOTS*SIDES*BANK_W-1:0]   pin_out,
  output logic [SLOTS*SIDES*BANK_W-1:0]   pin_oe
);

  localparam int NBANK  = SLOTS * SIDES;
  localparam int PINS   = NBANK * BANK_W;
  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  reg_kind_e               kind;
  logic [BIDX_W-1:0]       bank;
  logic [PINS-1:0]         oe_q;
  logic [PINS-1:0]         val_q;
  logic [NBANK-1:0]        dbg_q;
  logic [PINS-1:0]         pin_sync;
  logic [BANK_W-1:0]       rd_word;

  gpio_addr_decode #(
    .NBANK  (NBANK),
    .ADDR_W (ADDR_W),
    .DBG_IDX(DBG_IDX),
    .BIDX_W (BIDX_W)
  ) i_decode (
    .addr(host_addr),
    .kind(kind),
    .bank(bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic we_oe;
    logic we_val;
    assign we_oe  = host_wr && (kind == KIND_OE)  && (bank == BIDX_W'(b));
    assign we_val = host_wr && (kind == KIND_VAL) && (bank == BIDX_W'(b));

    gpio_bank_regs #(.W(BANK_W)) i_regs (
      .clk   (clk),
      .rst   (rst),
      .we_oe (we_oe),
      .we_val(we_val),
      .wdata (host_wdata),
      .wmask (host_wmask),
      .oe_q  (oe_q[b*BANK_W +: BANK_W]),
      .val_q (val_q[b*BANK_W +: BANK_W])
    );

    gpio_pin_drive #(.W(BANK_W)) i_drive (
      .clk    (clk),
      .rst    (rst),
      .dbg_sel(dbg_q[b]),
      .oe_in  (oe_q[b*BANK_W +: BANK_W]),
      .val_in (val_q[b*BANK_W +: BANK_W]),
      .dbg_in (dbg_bus[b*BANK_W +: BANK_W]),
      .pad_out(pin_out[b*BANK_W +: BANK_W]),
      .pad_oe (pin_oe[b*BANK_W +: BANK_W])
    );
  end

  // Debug-enable register, one bit per bank, same masked write rule.
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q <= '0;
    end else if (host_wr && kind == KIND_DBG) begin
      dbg_q <= (dbg_q & ~host_wmask[NBANK-1:0]) |
               (host_wdata[NBANK-1:0] & host_wmask[NBANK-1:0]);
    end
  end

  gpio_in_sync #(.WIDTH(PINS)) i_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_in),
    .dout(pin_sync)
  );

  always_comb begin
    unique case (kind)
      KIND_OE:  rd_word = oe_q[bank*BANK_W +: BANK_W];
      KIND_VAL: rd_word = val_q[bank*BANK_W +: BANK_W];
      KIND_PIN: rd_word = pin_sync[bank*BANK_W +: BANK_W];
      KIND_DBG: rd_word = BANK_W'(dbg_q);
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_word;
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NBANK   = 4,
  parameter int W       = 16,
  parameter int ADDR_W  = 5,
  parameter int DBG_IDX = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 host_wr,
  input logic                 host_rd,
  input logic [ADDR_W-1:0]    host_addr,
  input logic [W-1:0]         host_wdata,
  input logic [W-1:0]         host_wmask,
  input logic [W-1:0]         host_rdata,
  input logic [NBANK*W-1:0]   dbg_bus,
  input logic [NBANK*W-1:0]   pin_out,
  input logic [NBANK*W-1:0]   pin_oe,
  input logic [NBANK*W-1:0]   oe_q,
  input logic [NBANK*W-1:0]   val_q,
  input logic [NBANK-1:0]     dbg_q
);

  localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(2 * NBANK);
  localparam logic [ADDR_W-1:0] END_IDX  = ADDR_W'(3 * NBANK);
  localparam logic [ADDR_W-1:0] DBG_A    = ADDR_W'(DBG_IDX);

  logic wr_dead;
  logic rd_dead;
  assign wr_dead = (host_addr >= PIN_BASE) && (host_addr != DBG_A);
  assign rd_dead = (host_addr >= END_IDX)  && (host_addr != DBG_A);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (oe_q == '0 && val_q == '0 && dbg_q == '0 &&
             pin_oe == '0 && pin_out == '0 && host_rdata == '0));

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_oe == $past(oe_q));

  // R6
  dbg_write_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == DBG_A) |=>
      dbg_q == (($past(dbg_q) & ~$past(host_wmask[NBANK-1:0])) |
                ($past(host_wdata[NBANK-1:0]) & $past(host_wmask[NBANK-1:0]))));

  // R8
  dead_write_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && wr_dead) |=> ($stable(oe_q) && $stable(val_q) && $stable(dbg_q)));

  // R9
  dead_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && rd_dead) |=> host_rdata == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    // R3
    oe_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_addr == ADDR_W'(b)) |=>
        (((oe_q[b*W +: W] ^ $past(oe_q[b*W +: W])) & ~$past(host_wmask)) == '0 &&
         ((oe_q[b*W +: W] ^ $past(host_wdata)) & $past(host_wmask)) == '0));

    // R4
    val_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_addr == ADDR_W'(NBANK + b)) |=>
        (((val_q[b*W +: W] ^ $past(val_q[b*W +: W])) & ~$past(host_wmask)) == '0 &&
         ((val_q[b*W +: W] ^ $past(host_wdata)) & $past(host_wmask)) == '0));

    // R7
    dbg_drive_chk: assert property (@(posedge clk) disable iff (rst)
      $past(dbg_q[b]) |-> pin_out[b*W +: W] == $past(dbg_bus[b*W +: W]));
  end

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NBANK  (SLOTS * 2),
  .W      (BANK_W),
  .ADDR_W (ADDR_W),
  .DBG_IDX(DBG_IDX)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .host_wmask(host_wmask),
  .host_rdata(host_rdata),
  .dbg_bus   (dbg_bus),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .oe_q      (oe_q),
  .val_q     (val_q),
  .dbg_q     (dbg_q)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  localparam int W  = 16;
  localparam int NB = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic            host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0]   host_addr = '0;
  logic [W-1:0]    host_wdata = '0, host_wmask = '0;
  logic [W-1:0]    host_rdata;
  logic [NB*W-1:0] dbg_bus = '0, pin_in = '0;
  logic [NB*W-1:0] pin_out, pin_oe;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_wmask(host_wmask),
    .host_rdata(host_rdata), .dbg_bus(dbg_bus), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int total = 0, bad = 0, cyc = 0;
  bit started = 0;

  task automatic chk(input string tag, input logic [NB*W-1:0] act, input logic [NB*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [W-1:0]    m_oe [NB];
  logic [W-1:0]    m_val[NB];
  logic [NB-1:0]   m_dbg;
  logic [NB*W-1:0] m_s1, m_s2, m_pout, m_poe;
  logic [W-1:0]    m_rd;

  function automatic logic [W-1:0] m_lookup(input int a);
    if (a < NB)          return m_oe[a];
    else if (a < 2*NB)   return m_val[a-NB];
    else if (a < 3*NB)   return m_s2[(a-2*NB)*W +: W];
    else if (a == 14)    return W'(m_dbg);
    return '0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int b = 0; b < NB; b++) begin m_oe[b] = '0; m_val[b] = '0; end
      m_dbg = '0; m_s1 = '0; m_s2 = '0; m_pout = '0; m_poe = '0; m_rd = '0;
    end else begin
      int a;
      a = int'(host_addr);
      if (host_rd) m_rd = m_lookup(a);
      for (int b = 0; b < NB; b++) begin
        m_poe[b*W +: W]  = m_oe[b];
        m_pout[b*W +: W] = m_dbg[b] ? dbg_bus[b*W +: W] : m_val[b];
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (host_wr) begin
        if (a < NB)        m_oe[a]     = (m_oe[a] & ~host_wmask) | (host_wdata & host_wmask);
        else if (a < 2*NB) m_val[a-NB] = (m_val[a-NB] & ~host_wmask) | (host_wdata & host_wmask);
        else if (a == 14)  m_dbg = (m_dbg & ~host_wmask[NB-1:0]) | (host_wdata[NB-1:0] & host_wmask[NB-1:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R2 pin_oe vs model", pin_oe, m_poe);
      chk("R7 pin_out vs model", pin_out, m_pout);
      chk("R11 host_rdata vs model", {{(NB*W-W){1'b0}}, host_rdata}, {{(NB*W-W){1'b0}}, m_rd});
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [W-1:0] d, input logic [W-1:0] m);
    host_wr = 1'b1; host_addr = AW'(a); host_wdata = d; host_wmask = m;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] q);
    host_rd = 1'b1; host_addr = AW'(a);
    @(negedge clk);
    host_rd = 1'b0;
    q = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] slice(input logic [NB*W-1:0] v, input int b);
    return v[b*W +: W];
  endfunction

  logic [W-1:0] q;

  initial begin
    idle(4);
    // R1 reset state
    chk("R1 pin_oe after reset", pin_oe, '0);
    chk("R1 pin_out after reset", pin_out, '0);
    chk("R1 rdata after reset", host_rdata, '0);
    rst = 1'b0;
    idle(1);

    // R3 / R4 masked writes
    wr(0, 16'hFFFF, 16'hFFFF);
    wr(4, 16'hA5A5, 16'hFFFF);
    wr(4, 16'h0000, 16'h00F0);
    rd(4, q); chk("R4 masked value write", q, 16'hA505);
    wr(1, 16'h00FF, 16'h0F0F);
    wr(1, 16'hFFFF, 16'hF000);
    rd(1, q); chk("R3 masked enable write", q, 16'hF00F);
    idle(2);

    // R10 timing: write then pin two edges later
    wr(4, 16'h1234, 16'hFFFF);
    chk("R10 pin_out unchanged one edge after write", slice(pin_out, 0), 16'hA505);
    idle(1);
    chk("R10 pin_out updated two edges after write", slice(pin_out, 0), 16'h1234);
    chk("R2 pin_oe bank0", slice(pin_oe, 0), 16'hFFFF);
    chk("R2 pin_oe bank1", slice(pin_oe, 1), 16'hF00F);
    chk("R2 pin_oe bank3", slice(pin_oe, 3), 16'h0000);

    // R6 / R7 debug override
    dbg_bus = {16'hD333, 16'hD222, 16'hD111, 16'hD000};
    wr(2, 16'h00FF, 16'hFFFF);
    wr(14, 16'h0004, 16'h000F);
    idle(2);
    chk("R6 bit2 selects slot1 transmit bank", slice(pin_out, 2), 16'hD222);
    chk("R7 enable unchanged under debug", slice(pin_oe, 2), 16'h00FF);
    chk("R6 bank0 keeps host value", slice(pin_out, 0), 16'h1234);
    wr(14, 16'h0001, 16'h000F);
    idle(1);
    chk("R6 bit0 selects slot0 transmit bank", slice(pin_out, 0), 16'hD000);
    chk("R6 bank2 back to host value", slice(pin_out, 2), 16'h0000);
    dbg_bus[15:0] = 16'h5A5A;
    idle(1);
    chk("R7 pin follows debug bus", slice(pin_out, 0), 16'h5A5A);
    rd(14, q); chk("R11 debug-enable readback", q, 16'h0001);

    // R8 writes to unused or read-only indices ignored
    wr(8, 16'hFFFF, 16'hFFFF);
    wr(12, 16'hFFFF, 16'hFFFF);
    wr(13, 16'hFFFF, 16'hFFFF);
    wr(15, 16'hFFFF, 16'hFFFF);
    wr(31, 16'hFFFF, 16'hFFFF);
    rd(0, q);  chk("R8 bank0 enable kept", q, 16'hFFFF);
    rd(1, q);  chk("R8 bank1 enable kept", q, 16'hF00F);
    rd(4, q);  chk("R8 bank0 value kept", q, 16'h1234);
    rd(7, q);  chk("R8 bank3 value kept", q, 16'h0000);
    rd(14, q); chk("R8 debug-enable kept", q, 16'h0001);

    // R9 reads of unused indices
    rd(12, q); chk("R9 read index 12", q, 16'h0000);
    rd(31, q); chk("R9 read index 31", q, 16'h0000);

    // R5 synchronised pin read-back (bank0 is an output bank)
    pin_in = {16'h4444, 16'h3333, 16'h2222, 16'hC3C3};
    rd(8, q);  chk("R5 read before sync delay", q, 16'h0000);
    idle(2);
    rd(8, q);  chk("R5 output bank reads pad level", q, 16'hC3C3);
    rd(11, q); chk("R5 input bank reads pad level", q, 16'h4444);

    // R1 mid-run reset
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd(0, q);  chk("R1 enable cleared by reset", q, 16'h0000);
    rd(14, q); chk("R1 debug-enable cleared by reset", q, 16'h0000);
    chk("R1 pins cleared by reset", pin_oe, '0);

    // random phase, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      host_wr    = ($urandom % 3) == 0;
      host_rd    = ($urandom % 2) == 0;
      host_addr  = AW'($urandom % 16);
      host_wdata = W'($urandom);
      host_wmask = W'($urandom);
      pin_in     = {$urandom, $urandom};
      dbg_bus    = {$urandom, $urandom};
      @(negedge clk);
    end
    host_wr = 1'b0;
    host_rd = 1'b0;
    idle(3);
    summary();
    $finish;
  end

endmodule